// File: doc/BRIEF.md
# Reloadable Core Clock Divider

This block takes a parent clock and produces a slower divided clock whose period is a small integer number of parent cycles. Software programs the division ratio through a two-word register interface: a ratio word and a control word. A ratio written into the ratio word is only held as a staged (shadow) value. The running divider keeps its current ratio until software performs a two-step reload. First it sets this clock's force flag in the control word. Then, in a later write, it raises the reload trigger bit while the force flag is still set. The staged value is then rounded into the legal set {4, 5, 6, 8} and applied at the next period boundary of the output.

An enable bit in the control word gates the divided output. A build-time parameter selects a variant without that bit, in which the output always runs. The ratio word sits at a parameterised byte offset from the control word. The enable bit position also moves with a parameter. Reading the ratio word returns the staged value exactly as written.

Top module: `reloadClkDiv`

## Requirements
- R1: After reset the control word reads 0, the ratio word reads a staged ratio of 8, the active ratio is 8, and in the gated variant the output is low.
- R2: The ratio word is at byte address RATIO_OFFSET, and the control word is at address 0. The staged ratio sits in bits [13:8] and reads back unmodified. All other bits of the ratio word, and any unmapped address, read 0.
- R3: Writing the ratio word without a reload leaves the output period and duty unchanged.
- R4: A reload is requested by a control write that sets bit 8 (trigger) while bit 8 was previously 0, with bit 1 (force) set in the same written value. The staged ratio at that moment becomes the active ratio.
- R5: A control write that sets the trigger bit with the force bit clear does not change the active ratio.
- R6: At reload, the staged values 0 to 4 give 4, the values 5 and 6 are kept, and the values 7 to 63 give 8.
- R7: For active ratio r the output is high for floor(r/2) parent cycles and low for r - floor(r/2) parent cycles.
- R8: A new ratio takes effect only at the end of a complete output period. Every observed period matches either the old pattern or the new one.
- R9: Clearing the force and trigger bits after a reload leaves the active ratio unchanged, and so does a later write to the ratio word.
- R10: In the gated variant the enable is bit 1+ENABLE_OFFSET of the control word, and the output stays low while it is 0. In the ungated variant that bit reads 0 and the output always runs.
- R11: When the output is enabled it starts with a complete high phase of floor(r/2) cycles, and a reload done while disabled is in force from that first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| divOut | output | 1 | Divided, registered output clock |

## Verification
On every cycle the assertions check the following: the active ratio is always a legal value; the period counter stays below it; the active ratio only changes at a period boundary and only when a reload is pending; a pending reload only appears after a trigger write with force set; and the output is low one cycle after the divider stops running. The bench scenarios cover everything that needs a full period to show. It sweeps all 64 staged values through a reload and compares high and low phase lengths against the rounding rule. It confirms that a staged write, a trigger without force and the clearing writes leave the period alone. It shows that a reload landing mid-period yields only whole old or whole new periods. It also shows the first phase after enabling.

// File: rtl/clkdivPkg.sv
package clkdivPkg;
  localparam int RATIO_W = 6;
  typedef logic [RATIO_W-1:0] ratio_t;

  // Strobes handed from the register side to the divider datapath
  typedef struct packed {
    logic   loadReq;
    ratio_t loadRatio;
    logic   run;
  } strobe_t;

  // Round a requested ratio into the supported set {lo..mid, top}
  function automatic ratio_t legalizeRatio(ratio_t raw, ratio_t lo, ratio_t mid, ratio_t top);
    if (raw <= lo)       return lo;
    else if (raw <= mid) return raw;
    else                 return top;
  endfunction
endpackage

// File: rtl/clkdivRegs.sv
module clkdivRegs
  import clkdivPkg::*;
#(
  parameter int     ADDR_W       = 4,
  parameter int     DATA_W       = 32,
  parameter int     RATIO_OFFSET = 4,
  parameter int     RATIO_LSB    = 8,
  parameter int     FORCE_BIT    = 1,
  parameter int     TRIG_BIT     = 8,
  parameter int     ENABLE_BIT   = 17,
  parameter bit     HAS_ENABLE   = 1'b1,
  parameter ratio_t RESET_RATIO  = 6'd8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output strobe_t           strobes
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = '0;
  localparam logic [ADDR_W-1:0] RATIO_ADDR = ADDR_W'(RATIO_OFFSET);

  logic   forceQ, trigQ, enQ;
  ratio_t shadowQ;
  logic   ctrlHit, ratioHit;

  assign ctrlHit  = wrEn && (addr == CTRL_ADDR);
  assign ratioHit = wrEn && (addr == RATIO_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceQ  <= 1'b0;
      trigQ   <= 1'b0;
      enQ     <= 1'b0;
      shadowQ <= RESET_RATIO;
    end else begin
      if (ctrlHit) begin
        forceQ <= wrData[FORCE_BIT];
        trigQ  <= wrData[TRIG_BIT];
        enQ    <= HAS_ENABLE && wrData[ENABLE_BIT];
      end
      if (ratioHit) shadowQ <= wrData[RATIO_LSB +: RATIO_W];
    end
  end

  // Reload on a rising trigger with force set in the same word
  always_comb begin
    strobes.loadReq   = ctrlHit && wrData[TRIG_BIT] && wrData[FORCE_BIT] && !trigQ;
    strobes.loadRatio = shadowQ;
  end

  generate
    if (HAS_ENABLE) begin : g_gated
      assign strobes.run = enQ;
    end else begin : g_free
      assign strobes.run = 1'b1;
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (addr == CTRL_ADDR) begin
      rdData[FORCE_BIT]  = forceQ;
      rdData[TRIG_BIT]   = trigQ;
      rdData[ENABLE_BIT] = enQ;
    end else if (addr == RATIO_ADDR) begin
      rdData[RATIO_LSB +: RATIO_W] = shadowQ;
    end
  end
endmodule

// File: rtl/clkdivCore.sv
module clkdivCore
  import clkdivPkg::*;
#(
  parameter ratio_t RESET_RATIO = 6'd8,
  parameter ratio_t MIN_RATIO   = 6'd4,
  parameter ratio_t MID_RATIO   = 6'd6,
  parameter ratio_t TOP_RATIO   = 6'd8
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  output logic    divOut
);
  localparam ratio_t ONE = ratio_t'(1);

  ratio_t actQ, pendQ, cntQ;
  logic   pendValidQ, outQ;
  ratio_t actNext, cntNext;
  logic   applyNow, lastCnt, outNext;

  always_comb begin
    lastCnt  = (cntQ == actQ - ONE);
    applyNow = 1'b0;
    actNext  = actQ;
    cntNext  = cntQ + ONE;
    if (!strobes.run) begin
      // Idle sits at the period boundary so that a start gives a full period
      applyNow = pendValidQ;
      if (applyNow) actNext = pendQ;
      cntNext = actNext - ONE;
    end else if (lastCnt) begin
      applyNow = pendValidQ;
      if (applyNow) actNext = pendQ;
      cntNext = '0;
    end
    outNext = strobes.run && (cntNext < (actNext >> 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ       <= RESET_RATIO;
      cntQ       <= RESET_RATIO - ONE;
      pendQ      <= RESET_RATIO;
      pendValidQ <= 1'b0;
      outQ       <= 1'b0;
    end else begin
      actQ <= actNext;
      cntQ <= cntNext;
      outQ <= outNext;
      if (strobes.loadReq) begin
        pendQ      <= legalizeRatio(strobes.loadRatio, MIN_RATIO, MID_RATIO, TOP_RATIO);
        pendValidQ <= 1'b1;
      end else if (applyNow) begin
        pendValidQ <= 1'b0;
      end
    end
  end

  assign divOut = outQ;
endmodule

// File: rtl/reloadClkDiv.sv
module reloadClkDiv
  import clkdivPkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int RATIO_OFFSET  = 4,
  parameter int ENABLE_OFFSET = 16,
  parameter bit HAS_ENABLE    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              divOut
);
  localparam int     DATA_W     = 32;
  localparam int     FORCE_BIT  = 1;
  localparam int     TRIG_BIT   = 8;
  localparam int     RATIO_LSB  = 8;
  localparam int     ENABLE_BIT = FORCE_BIT + ENABLE_OFFSET;
  localparam ratio_t MIN_RATIO  = 6'd4;
  localparam ratio_t MID_RATIO  = 6'd6;
  localparam ratio_t TOP_RATIO  = 6'd8;

  strobe_t strobes;

  clkdivRegs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_OFFSET(RATIO_OFFSET),
    .RATIO_LSB(RATIO_LSB), .FORCE_BIT(FORCE_BIT), .TRIG_BIT(TRIG_BIT),
    .ENABLE_BIT(ENABLE_BIT), .HAS_ENABLE(HAS_ENABLE), .RESET_RATIO(TOP_RATIO)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strobes(strobes)
  );

  clkdivCore #(
    .RESET_RATIO(TOP_RATIO), .MIN_RATIO(MIN_RATIO),
    .MID_RATIO(MID_RATIO), .TOP_RATIO(TOP_RATIO)
  ) u_core (
    .clk(clk), .rstN(rstN), .strobes(strobes), .divOut(divOut)
  );
endmodule

// File: rtl/reloadClkDivChk.sv
module reloadClkDivChk
  import clkdivPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int FORCE_BIT = 1,
  parameter int TRIG_BIT  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              divOut,
  input logic              run,
  input ratio_t            actRatio,
  input ratio_t            cntVal,
  input logic              pendValid
);
  // R6: only legal ratios ever become active
  assert_active_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (actRatio == 6'd4 || actRatio == 6'd5 || actRatio == 6'd6 || actRatio == 6'd8));

  // R7: period counter stays inside the active period
  assert_counter_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    cntVal < actRatio);

  // R8: ratio changes only at the end of a period
  assert_switch_at_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actRatio) |-> ($past(cntVal) == $past(actRatio) - ratio_t'(1)));

  // R4: ratio changes only from a pending reload
  assert_switch_needs_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actRatio) |-> $past(pendValid));

  // R5: a reload becomes pending only after trigger with force set
  assert_reload_on_trigger_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendValid) |-> $past(wrEn && addr == '0 && wrData[TRIG_BIT] && wrData[FORCE_BIT]));

  // R10: a stopped divider drives its output low
  assert_gated_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(run) |-> !divOut);
endmodule

bind reloadClkDiv reloadClkDivChk #(
  .ADDR_W(ADDR_W), .FORCE_BIT(FORCE_BIT), .TRIG_BIT(TRIG_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .divOut(divOut), .run(strobes.run), .actRatio(u_core.actQ),
  .cntVal(u_core.cntQ), .pendValid(u_core.pendValidQ)
);

// File: tb/reloadClkDiv_tb.sv
`timescale 1ns/1ps
module reloadClkDiv_tb;
  localparam int ADDR_W = 4;
  localparam logic [31:0] FORCE = 32'h1 << 1;
  localparam logic [31:0] TRIG  = 32'h1 << 8;
  localparam logic [31:0] EN_A  = 32'h1 << 17; // gated instance, enable offset 16
  localparam logic [31:0] EN_B  = 32'h1 << 25; // ungated instance, enable offset 24
  localparam int RATIO_A = 4;
  localparam int RATIO_B = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEnA = 1'b0, wrEnB = 1'b0;
  logic [ADDR_W-1:0] addrA = '0, addrB = '0;
  logic [31:0] wrDataA = '0, wrDataB = '0;
  logic [31:0] rdDataA, rdDataB;
  logic divOutA, divOutB;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  reloadClkDiv #(.ADDR_W(ADDR_W), .RATIO_OFFSET(RATIO_A), .ENABLE_OFFSET(16), .HAS_ENABLE(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEnA), .addr(addrA), .wrData(wrDataA),
    .rdData(rdDataA), .divOut(divOutA));

  reloadClkDiv #(.ADDR_W(ADDR_W), .RATIO_OFFSET(RATIO_B), .ENABLE_OFFSET(24), .HAS_ENABLE(1'b0)) u_dutAlt (
    .clk(clk), .rstN(rstN), .wrEn(wrEnB), .addr(addrB), .wrData(wrDataB),
    .rdData(rdDataB), .divOut(divOutB));

  function automatic logic outOf(int which);
    return (which == 0) ? divOutA : divOutB;
  endfunction

  function automatic int legalOf(int v);
    if (v <= 4) return 4;
    else if (v <= 6) return v;
    else return 8;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(int which, int a, logic [31:0] d);
    @(negedge clk);
    if (which == 0) begin wrEnA = 1'b1; addrA = ADDR_W'(a); wrDataA = d; end
    else begin wrEnB = 1'b1; addrB = ADDR_W'(a); wrDataB = d; end
    @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0;
  endtask

  task automatic busRead(int which, int a, output logic [31:0] d);
    @(negedge clk);
    if (which == 0) addrA = ADDR_W'(a); else addrB = ADDR_W'(a);
    #1;
    d = (which == 0) ? rdDataA : rdDataB;
  endtask

  task automatic reloadSeq(int which, int ratio, logic [31:0] en);
    busWrite(which, (which == 0) ? RATIO_A : RATIO_B, 32'(ratio) << 8);
    busWrite(which, 0, FORCE | en);
    busWrite(which, 0, FORCE | TRIG | en);
    busWrite(which, 0, en);
  endtask

  // Called right after a negedge sample that saw the output high
  task automatic measureFromRise(int which, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (outOf(which) === 1'b1 && guard < 100) begin hi++; guard++; @(negedge clk); end
    while (outOf(which) === 1'b0 && guard < 100) begin lo++; guard++; @(negedge clk); end
  endtask

  task automatic waitRise(int which);
    int guard = 0;
    @(negedge clk);
    while (outOf(which) !== 1'b0 && guard < 100) begin guard++; @(negedge clk); end
    while (outOf(which) !== 1'b1 && guard < 100) begin guard++; @(negedge clk); end
  endtask

  task automatic measurePeriod(int which, output int hi, output int lo);
    waitRise(which);
    measureFromRise(which, hi, lo);
  endtask

  task automatic expectLow(int which, int n, string tag);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outOf(which) !== 1'b0) highs++;
    end
    check(highs == 0, tag, 32'(highs), 32'd0);
  endtask

  // Enable the gated instance, check start latency and first high phase
  task automatic enableAndCheck(int ratio, string tag);
    int wait1 = 0;
    int hi = 0;
    int guard = 0;
    busWrite(0, 0, EN_A);
    @(negedge clk);
    while (divOutA !== 1'b1 && guard < 20) begin wait1++; guard++; @(negedge clk); end
    while (divOutA === 1'b1 && guard < 40) begin hi++; guard++; @(negedge clk); end
    check(wait1 == 0, {tag, " start latency"}, 32'(wait1), 32'd0);
    check(hi == ratio / 2, {tag, " first high"}, 32'(hi), 32'(ratio / 2));
  endtask

  initial begin
    int hi, lo, e;
    logic [31:0] d;
    int hiArr[6];
    int loArr[6];

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    busRead(0, 0, d);       check(d == 0, "R1 ctrl reset", d, 0);
    busRead(0, RATIO_A, d); check(d == (32'd8 << 8), "R1 ratio reset", d, 32'd8 << 8);
    busRead(1, RATIO_B, d); check(d == (32'd8 << 8), "R1 alt ratio reset", d, 32'd8 << 8);
    expectLow(0, 20, "R1 gated output low after reset");
    measurePeriod(1, hi, lo);
    check(hi == 4 && lo == 4, "R1 alt reset period hi", 32'(hi), 4);
    check(lo == 4, "R1 alt reset period lo", 32'(lo), 4);

    // R2: unmapped reads and offsets
    busRead(0, 8, d); check(d == 0, "R2 unmapped read", d, 0);
    busRead(1, 4, d); check(d == 0, "R2 alt unmapped read", d, 0);

    // R11 / R10: enable, then disable
    enableAndCheck(8, "R11 enable");
    busRead(0, 0, d); check(d == EN_A, "R10 enable bit readback", d, EN_A);
    busWrite(0, 0, 32'd0);
    expectLow(0, 20, "R10 output low when disabled");
    busWrite(0, 0, EN_A);

    // R3: staged write alone changes nothing
    busWrite(0, RATIO_A, 32'd5 << 8);
    busRead(0, RATIO_A, d); check(d == (32'd5 << 8), "R3 staged readback", d, 32'd5 << 8);
    measurePeriod(0, hi, lo);
    measurePeriod(0, hi, lo);
    check(hi == 4 && lo == 4, "R3 period unchanged", 32'(hi * 16 + lo), 32'(4 * 16 + 4));

    // R5: trigger without force does nothing
    busWrite(0, 0, TRIG | EN_A);
    busWrite(0, 0, EN_A);
    measurePeriod(0, hi, lo);
    measurePeriod(0, hi, lo);
    check(hi == 4 && lo == 4, "R5 no reload without force", 32'(hi * 16 + lo), 32'(4 * 16 + 4));

    // R4 / R6 / R7 / R2: sweep every staged value through a reload
    for (int v = 0; v < 64; v++) begin
      busWrite(0, RATIO_A, 32'(v) << 8);
      busRead(0, RATIO_A, d);
      check(d == (32'(v) << 8), "R2 ratio readback", d, 32'(v) << 8);
      busWrite(0, 0, FORCE | EN_A);
      busWrite(0, 0, FORCE | TRIG | EN_A);
      busWrite(0, 0, EN_A);
      measurePeriod(0, hi, lo);
      measurePeriod(0, hi, lo);
      e = legalOf(v);
      check(hi == e / 2, "R6 R7 high phase after reload", 32'(hi), 32'(e / 2));
      check(lo == e - e / 2, "R4 R7 low phase after reload", 32'(lo), 32'(e - e / 2));
    end

    // R9: clearing and a later staged write keep the ratio
    reloadSeq(0, 5, EN_A);
    busWrite(0, 0, EN_A);
    busWrite(0, RATIO_A, 32'd6 << 8);
    busWrite(0, 0, EN_A);
    measurePeriod(0, hi, lo);
    measurePeriod(0, hi, lo);
    check(hi == 2 && lo == 3, "R9 ratio kept after clear", 32'(hi * 16 + lo), 32'(2 * 16 + 3));
    busRead(0, 0, d); check(d == EN_A, "R9 ctrl cleared", d, EN_A);

    // R8: reload landing mid-period from 8 to 5
    reloadSeq(0, 8, EN_A);
    measurePeriod(0, hi, lo);
    waitRise(0);
    fork
      begin
        for (int p = 0; p < 6; p++) measureFromRise(0, hiArr[p], loArr[p]);
      end
      begin
        repeat (2) @(negedge clk);
        reloadSeq(0, 5, EN_A);
      end
    join
    begin
      bit seenNew = 0;
      bit bad = 0;
      for (int p = 0; p < 6; p++) begin
        if (hiArr[p] == 2 && loArr[p] == 3) seenNew = 1;
        else if (hiArr[p] == 4 && loArr[p] == 4) begin if (seenNew) bad = 1; end
        else bad = 1;
      end
      check(!bad, "R8 only whole periods", 32'(hiArr[0] * 16 + loArr[0]), 32'(4 * 16 + 4));
      check(hiArr[5] == 2 && loArr[5] == 3, "R8 new ratio in force",
            32'(hiArr[5] * 16 + loArr[5]), 32'(2 * 16 + 3));
    end

    // R11: reload while disabled is in force from the first period
    busWrite(0, 0, 32'd0);
    reloadSeq(0, 6, 32'd0);
    expectLow(0, 10, "R10 low while disabled after reload");
    enableAndCheck(6, "R11 reload while disabled");
    measurePeriod(0, hi, lo);
    check(hi == 3 && lo == 3, "R11 period after enable", 32'(hi * 16 + lo), 32'(3 * 16 + 3));

    // R10: ungated variant ignores the enable bit and keeps running
    busWrite(1, 0, EN_B);
    busRead(1, 0, d); check(d == 0, "R10 alt enable bit reads 0", d, 0);
    busWrite(1, 0, 32'd0);
    reloadSeq(1, 6, 32'd0);
    busRead(1, RATIO_B, d); check(d == (32'd6 << 8), "R2 alt ratio readback", d, 32'd6 << 8);
    measurePeriod(1, hi, lo);
    measurePeriod(1, hi, lo);
    check(hi == 3 && lo == 3, "R10 alt runs with enable clear", 32'(hi * 16 + lo), 32'(3 * 16 + 3));

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule